// File: doc/BRIEF.md
# Dual-Processor Mailbox FIFO

Two processors, A and B, share this block to exchange words and small status values. Each side has a register port with four selectable targets. The first is a signalling register whose 4-bit output nibble shows up as the input nibble of the other side. The second is a control and status word. The third is a write-only push port into that side's outgoing queue. The fourth is a read-only pop port that drains the queue the other side fills. The two directions each own a 32-bit wide, 16-deep queue, so traffic A-to-B and B-to-A never interferes.

Each side keeps its own enable bit, its own sticky error flag and its own last-read word. The status bits are cross-coupled. A side's outgoing-queue occupancy is shown as "send empty/full" to that side and as "receive empty/full" to the other side. A read from an empty queue does not stall. It raises the reader's error flag and returns the last word that reader obtained, or zero if it has obtained none. The control and signalling registers use only their low 16 bits, so halfword and word writes behave identically.

Each queue is managed by a three-state controller:
- States: EMPTY, PARTIAL and FULL.
- Transitions: FILL_FIRST (EMPTY to PARTIAL on an accepted push), TOP_OFF (PARTIAL to FULL when a lone push brings the count to the depth), DRAIN_ONE (FULL to PARTIAL on a lone pop) and DRAIN_LAST (PARTIAL to EMPTY when a lone pop takes the final word).
- A push and a pop in the same cycle leave the state unchanged.

Each port also classifies its current access as one of IDLE, WR_SYNC, WR_CTRL, SEND, RD_SYNC, RD_CTRL, RECV or NONE.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, each side's control word reads 0x0101 and each side's signalling word reads 0x0000. Control word layout: bit 0 send-empty, bit 1 send-full, bit 8 receive-empty, bit 9 receive-full, bit 14 error, bit 15 enable. Bits 2, 3 and 10 are plain storage; all other bits read 0. Select codes: 0 signalling, 1 control, 2 push, 3 pop.
- R2: A signalling write stores only the written bits 14:13 and 11:8; every other written bit is discarded.
- R3: After a signalling write by one side, the written bits 11:8 read back as bits 3:0 of the other side's signalling word. Bits 3:0 of a side's own write have no effect.
- R4: A control write stores bits 15, 10, 3 and 2 from the written data. The flag bits 0, 1, 8 and 9 cannot be written.
- R5: Writing 1 to control bit 14 clears the error flag. Writing 0 leaves it as it was. No write can set it.
- R6: A push while the pushing side's enable bit is 0 is discarded and leaves every flag unchanged.
- R7: With enable set, a push appends the word to the side's outgoing 16-entry queue. The flags follow the occupancy at once: send-empty and the peer's receive-empty when it is 0; send-full and the peer's receive-full when it is 16.
- R8: A pop with the reader's enable set returns the oldest word of the peer's queue and removes it. With enable clear it returns the oldest word and leaves it in place.
- R9: A pop from an empty queue sets the reader's error flag. It returns the last word that reader obtained, or 0 if it has never obtained one.
- R10: A push to a full queue is discarded, sets the pusher's error flag and leaves the stored words intact.
- R11: A push and a pop on one queue in the same cycle are both carried out and leave the occupancy unchanged. Fullness and emptiness are judged on the occupancy at the start of the cycle.
- R12: Read data for a read access is presented from the clock edge that accepts the access and holds until the next read on that side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_req | input | 1 | Side A access strobe, one cycle per access |
| a_we | input | 1 | Side A write (1) or read (0) |
| a_sel | input | 2 | Side A target: 0 signalling, 1 control, 2 push, 3 pop |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, registered |
| b_req | input | 1 | Side B access strobe |
| b_we | input | 1 | Side B write (1) or read (0) |
| b_sel | input | 2 | Side B target, same coding as side A |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, registered |

## Verification
Register and queue state changes on the clock edge that accepts an access. Flags, signalling nibbles and read data are therefore all due one cycle after the strobe is raised. The bench raises each strobe just after a falling edge and drops it at the next falling edge. It samples the read data at that same falling edge, half a period after the accepting rising edge. A flag or cross-coupled value that follows a write is checked with a read issued in the next cycle, so it is observed two edges after the write strobe. The simultaneous push-and-pop case is driven on both sides in one cycle, and its outcome is checked through the pop data and later reads.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

    typedef enum logic [1:0] {
        SEL_SYNC = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_PUSH = 2'd2,
        SEL_POP  = 2'd3
    } sel_t;

    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_PARTIAL = 2'd1,
        Q_FULL    = 2'd2
    } q_state_t;

    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_WR_SYNC,
        ACC_WR_CTRL,
        ACC_SEND,
        ACC_RD_SYNC,
        ACC_RD_CTRL,
        ACC_RECV,
        ACC_NONE
    } acc_t;

    localparam int REG_W      = 16;
    localparam int CB_SEMPTY  = 0;
    localparam int CB_SFULL   = 1;
    localparam int CB_SPARE0  = 2;
    localparam int CB_SPARE1  = 3;
    localparam int CB_REMPTY  = 8;
    localparam int CB_RFULL   = 9;
    localparam int CB_SPARE2  = 10;
    localparam int CB_ERR     = 14;
    localparam int CB_EN      = 15;
    localparam int SB_NIB_LO  = 8;
    localparam int SB_HI_LO   = 13;

endpackage

// File: rtl/ipc_queue_ctl.sv
module ipc_queue_ctl
    import ipc_pkg::*;
#(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic                         pop,
    input  logic [W-1:0]                 din,
    output logic [W-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]   occ,
    output logic                         empty,
    output logic                         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH-1);

    q_state_t        st_q, st_d;
    logic [W-1:0]    mem [DEPTH];
    logic [AW-1:0]   wp_q, rp_q;
    logic [CW-1:0]   occ_q;
    logic            push_ok, pop_ok;

    assign push_ok = push && (st_q != Q_FULL);
    assign pop_ok  = pop  && (st_q != Q_EMPTY);

    // next state: FILL_FIRST, TOP_OFF, DRAIN_ONE, DRAIN_LAST
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            Q_EMPTY: begin
                if (push_ok)
                    st_d = (DEPTH == 1) ? Q_FULL : Q_PARTIAL;
            end
            Q_PARTIAL: begin
                if (push_ok && !pop_ok && occ_q == CW'(DEPTH-1))
                    st_d = Q_FULL;
                else if (pop_ok && !push_ok && occ_q == CW'(1))
                    st_d = Q_EMPTY;
            end
            Q_FULL: begin
                if (pop_ok && !push_ok)
                    st_d = (DEPTH == 1) ? Q_EMPTY : Q_PARTIAL;
            end
            default: st_d = Q_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= Q_EMPTY;
        else        st_q <= st_d;
    end

    always_comb begin
        empty = (st_q == Q_EMPTY);
        full  = (st_q == Q_FULL);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            occ_q <= '0;
        end else begin
            if (push_ok) wp_q <= (wp_q == LAST) ? '0 : wp_q + AW'(1);
            if (pop_ok)  rp_q <= (rp_q == LAST) ? '0 : rp_q + AW'(1);
            occ_q <= occ_q + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp_q] <= din;
    end

    assign head = mem[rp_q];
    assign occ  = occ_q;

endmodule

// File: rtl/ipc_side_port.sv
module ipc_side_port
    import ipc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          we,
    input  logic [1:0]    sel,
    input  logic [W-1:0]  wdata,
    input  logic [3:0]    peer_nib,
    input  logic          tx_empty,
    input  logic          tx_full,
    input  logic          rx_empty,
    input  logic          rx_full,
    input  logic [W-1:0]  rx_head,
    output logic [W-1:0]  rdata,
    output logic          push,
    output logic          pop,
    output logic [3:0]    own_nib,
    output logic          en
);
    acc_t               acc;
    logic [1:0]         sync_hi_q;
    logic [3:0]         sync_nib_q;
    logic               en_q, err_q;
    logic [2:0]         spare_q;
    logic [W-1:0]       last_q, rdata_q;
    logic [REG_W-1:0]   sync_word, ctrl_word;
    logic               err_set;

    always_comb begin
        acc = ACC_IDLE;
        if (req) begin
            unique case (sel_t'(sel))
                SEL_SYNC: acc = we ? ACC_WR_SYNC : ACC_RD_SYNC;
                SEL_CTRL: acc = we ? ACC_WR_CTRL : ACC_RD_CTRL;
                SEL_PUSH: acc = we ? ACC_SEND    : ACC_NONE;
                SEL_POP:  acc = we ? ACC_NONE    : ACC_RECV;
                default:  acc = ACC_NONE;
            endcase
        end
    end

    assign push    = (acc == ACC_SEND) && en_q && !tx_full;
    assign pop     = (acc == ACC_RECV) && en_q && !rx_empty;
    assign err_set = ((acc == ACC_SEND) && en_q && tx_full) ||
                     ((acc == ACC_RECV) && rx_empty);

    always_comb begin
        sync_word = '0;
        sync_word[SB_HI_LO +: 2]  = sync_hi_q;
        sync_word[SB_NIB_LO +: 4] = sync_nib_q;
        sync_word[3:0]            = peer_nib;

        ctrl_word = '0;
        ctrl_word[CB_SEMPTY] = tx_empty;
        ctrl_word[CB_SFULL]  = tx_full;
        ctrl_word[CB_SPARE0] = spare_q[0];
        ctrl_word[CB_SPARE1] = spare_q[1];
        ctrl_word[CB_REMPTY] = rx_empty;
        ctrl_word[CB_RFULL]  = rx_full;
        ctrl_word[CB_SPARE2] = spare_q[2];
        ctrl_word[CB_ERR]    = err_q;
        ctrl_word[CB_EN]     = en_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_hi_q  <= '0;
            sync_nib_q <= '0;
            en_q       <= 1'b0;
            err_q      <= 1'b0;
            spare_q    <= '0;
            last_q     <= '0;
            rdata_q    <= '0;
        end else begin
            unique case (acc)
                ACC_WR_SYNC: begin
                    sync_hi_q  <= wdata[SB_HI_LO +: 2];
                    sync_nib_q <= wdata[SB_NIB_LO +: 4];
                end
                ACC_WR_CTRL: begin
                    en_q    <= wdata[CB_EN];
                    spare_q <= {wdata[CB_SPARE2], wdata[CB_SPARE1], wdata[CB_SPARE0]};
                    if (wdata[CB_ERR]) err_q <= 1'b0;
                end
                ACC_RD_SYNC: rdata_q <= W'(sync_word);
                ACC_RD_CTRL: rdata_q <= W'(ctrl_word);
                ACC_RECV: begin
                    if (rx_empty) begin
                        rdata_q <= last_q;
                    end else begin
                        rdata_q <= rx_head;
                        last_q  <= rx_head;
                    end
                end
                ACC_SEND, ACC_IDLE, ACC_NONE: ;
                default: ;
            endcase
            if (err_set) err_q <= 1'b1;
        end
    end

    assign rdata   = rdata_q;
    assign own_nib = sync_nib_q;
    assign en      = en_q;

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import ipc_pkg::*;
#(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_req,
    input  logic          a_we,
    input  logic [1:0]    a_sel,
    input  logic [W-1:0]  a_wdata,
    output logic [W-1:0]  a_rdata,
    input  logic          b_req,
    input  logic          b_we,
    input  logic [1:0]    b_sel,
    input  logic [W-1:0]  b_wdata,
    output logic [W-1:0]  b_rdata
);
    localparam int CW = $clog2(DEPTH+1);

    logic          ab_push, ab_pop, ab_empty, ab_full;
    logic          ba_push, ba_pop, ba_empty, ba_full;
    logic [W-1:0]  ab_head, ba_head;
    logic [CW-1:0] ab_occ, ba_occ;
    logic [3:0]    a_nib, b_nib;
    logic          a_en, b_en;

    ipc_queue_ctl #(.W(W), .DEPTH(DEPTH)) u_q_ab (
        .clk(clk), .rst_n(rst_n), .push(ab_push), .pop(ab_pop), .din(a_wdata),
        .head(ab_head), .occ(ab_occ), .empty(ab_empty), .full(ab_full)
    );

    ipc_queue_ctl #(.W(W), .DEPTH(DEPTH)) u_q_ba (
        .clk(clk), .rst_n(rst_n), .push(ba_push), .pop(ba_pop), .din(b_wdata),
        .head(ba_head), .occ(ba_occ), .empty(ba_empty), .full(ba_full)
    );

    ipc_side_port #(.W(W)) u_port_a (
        .clk(clk), .rst_n(rst_n), .req(a_req), .we(a_we), .sel(a_sel), .wdata(a_wdata),
        .peer_nib(b_nib), .tx_empty(ab_empty), .tx_full(ab_full),
        .rx_empty(ba_empty), .rx_full(ba_full), .rx_head(ba_head),
        .rdata(a_rdata), .push(ab_push), .pop(ba_pop), .own_nib(a_nib), .en(a_en)
    );

    ipc_side_port #(.W(W)) u_port_b (
        .clk(clk), .rst_n(rst_n), .req(b_req), .we(b_we), .sel(b_sel), .wdata(b_wdata),
        .peer_nib(a_nib), .tx_empty(ba_empty), .tx_full(ba_full),
        .rx_empty(ab_empty), .rx_full(ab_full), .rx_head(ab_head),
        .rdata(b_rdata), .push(ba_push), .pop(ab_pop), .own_nib(b_nib), .en(b_en)
    );

endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          a_req,
    input logic          a_we,
    input logic [1:0]    a_sel,
    input logic [W-1:0]  a_wdata,
    input logic          a_en,
    input logic [3:0]    a_nib,
    input logic          ab_push,
    input logic          ab_pop,
    input logic          ab_empty,
    input logic          ab_full,
    input logic [CW-1:0] ab_occ
);
    p_occ_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ab_occ <= CW'(DEPTH));

    p_empty_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ab_empty == (ab_occ == '0));

    p_full_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ab_full == (ab_occ == CW'(DEPTH)));

    p_drop_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (a_req && a_we && a_sel == 2'd2 && !a_en && !ab_pop) |=> $stable(ab_occ));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (a_req && a_we && a_sel == 2'd2 && ab_full && !ab_pop) |=> (ab_occ == CW'(DEPTH)));

    p_net_change_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_push && ab_pop) |=> $stable(ab_occ));

    p_pop_has_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ab_pop |-> !ab_empty);

    p_nib_follows_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (a_req && a_we && a_sel == 2'd0) |=> (a_nib == $past(a_wdata[11:8])));

endmodule

bind ipc_mailbox ipc_mailbox_chk #(.W(W), .DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .a_req(a_req), .a_we(a_we), .a_sel(a_sel),
    .a_wdata(a_wdata), .a_en(a_en), .a_nib(a_nib), .ab_push(ab_push),
    .ab_pop(ab_pop), .ab_empty(ab_empty), .ab_full(ab_full), .ab_occ(ab_occ)
);

// File: tb/test_ipc_mailbox.sv
`timescale 1ns/1ps
module test_ipc_mailbox;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_req = 1'b0, a_we = 1'b0, b_req = 1'b0, b_we = 1'b0;
    logic [1:0]  a_sel = '0, b_sel = '0;
    logic [31:0] a_wdata = '0, b_wdata = '0;
    logic [31:0] a_rdata, b_rdata;
    int          n_run = 0, n_fail = 0, cyc = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    ipc_mailbox i_ipc_mailbox (
        .clk(clk), .rst_n(rst_n),
        .a_req(a_req), .a_we(a_we), .a_sel(a_sel), .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_req(b_req), .b_we(b_we), .b_sel(b_sel), .b_wdata(b_wdata), .b_rdata(b_rdata)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog: run did not finish, actual cycles=%0d expected < 20000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%08h expected=%08h", r, act, exp);
        end
    endtask

    task automatic acc(input bit side, input logic [1:0] sel, input bit we,
                       input logic [31:0] wd, output logic [31:0] rd);
        @(negedge clk);
        if (!side) begin a_req = 1; a_we = we; a_sel = sel; a_wdata = wd; end
        else       begin b_req = 1; b_we = we; b_sel = sel; b_wdata = wd; end
        @(negedge clk);
        rd = side ? b_rdata : a_rdata;
        a_req = 0; b_req = 0;
    endtask

    task automatic wr(input bit side, input logic [1:0] sel, input logic [31:0] wd);
        logic [31:0] dummy;
        acc(side, sel, 1'b1, wd, dummy);
    endtask

    task automatic rd_chk(input bit side, input logic [1:0] sel, input logic [31:0] exp, input string r);
        logic [31:0] v;
        acc(side, sel, 1'b0, '0, v);
        chk(r, v, exp);
    endtask

    task automatic t_reset;
        rd_chk(0, 2'd1, 32'h0101, "R1 A ctrl");
        rd_chk(1, 2'd1, 32'h0101, "R1 B ctrl");
        rd_chk(0, 2'd0, 32'h0000, "R1 A sync");
        rd_chk(1, 2'd0, 32'h0000, "R1 B sync");
    endtask

    task automatic t_sync;
        wr(0, 2'd0, 32'h0000_FFFF);
        rd_chk(0, 2'd0, 32'h6F00, "R2 A sync mask");
        rd_chk(1, 2'd0, 32'h000F, "R3 B sees A nibble");
        wr(1, 2'd0, 32'h0000_0A05);
        rd_chk(1, 2'd0, 32'h0A0F, "R3 B own bits 3:0 ignored");
        rd_chk(0, 2'd0, 32'h6F0A, "R12 R3 A sees B nibble next cycle");
    endtask

    task automatic t_ctrl;
        wr(0, 2'd1, 32'h0000_FFFF);
        rd_chk(0, 2'd1, 32'h850D, "R4 R5 ctrl writable bits, err not settable");
        wr(0, 2'd1, 32'h0000_0000);
        rd_chk(0, 2'd1, 32'h0101, "R4 flags kept");
        wr(0, 2'd1, 32'h0000_8000);
        rd_chk(0, 2'd1, 32'h8101, "R4 enable set");
    endtask

    task automatic t_disabled_push;
        wr(1, 2'd2, 32'h1234_5678);
        rd_chk(1, 2'd1, 32'h0101, "R6 B flags unchanged");
        rd_chk(0, 2'd1, 32'h8101, "R6 A recv still empty");
    endtask

    task automatic t_order;
        wr(1, 2'd1, 32'h0000_8000);
        for (int i = 0; i < 3; i++) wr(0, 2'd2, 32'hA000_0000 + i);
        rd_chk(0, 2'd1, 32'h8100, "R7 A send not empty");
        rd_chk(1, 2'd1, 32'h8001, "R7 B recv not empty");
        for (int i = 0; i < 3; i++) rd_chk(1, 2'd3, 32'hA000_0000 + i, "R8 pop order");
        rd_chk(0, 2'd1, 32'h8101, "R7 A empty again");
    endtask

    task automatic t_peek;
        wr(0, 2'd2, 32'hBEEF_0001);
        wr(1, 2'd1, 32'h0000_0000);
        rd_chk(1, 2'd3, 32'hBEEF_0001, "R8 peek first");
        rd_chk(1, 2'd3, 32'hBEEF_0001, "R8 peek again");
        rd_chk(1, 2'd1, 32'h0001, "R8 peek leaves word");
        wr(1, 2'd1, 32'h0000_8000);
        rd_chk(1, 2'd3, 32'hBEEF_0001, "R8 pop after peek");
        rd_chk(1, 2'd1, 32'h8101, "R8 queue drained");
    endtask

    task automatic t_underflow;
        rd_chk(1, 2'd3, 32'hBEEF_0001, "R9 underflow returns last read");
        rd_chk(1, 2'd1, 32'hC101, "R9 B error set");
        rd_chk(0, 2'd3, 32'h0000_0000, "R9 never-read returns 0");
        rd_chk(0, 2'd1, 32'hC101, "R9 A error set");
        wr(1, 2'd1, 32'h0000_8000);
        rd_chk(1, 2'd1, 32'hC101, "R5 write 0 keeps error");
        wr(1, 2'd1, 32'h0000_C000);
        rd_chk(1, 2'd1, 32'h8101, "R5 write 1 clears error");
        wr(0, 2'd1, 32'h0000_C000);
        rd_chk(0, 2'd1, 32'h8101, "R5 A error cleared");
    endtask

    task automatic t_full;
        for (int i = 0; i < 16; i++) wr(0, 2'd2, 32'h0000_1000 + 3*i);
        rd_chk(0, 2'd1, 32'h8102, "R7 A send full");
        rd_chk(1, 2'd1, 32'h8201, "R7 B recv full");
        wr(0, 2'd2, 32'hDEAD_DEAD);
        rd_chk(0, 2'd1, 32'hC102, "R10 overflow sets error");
        for (int i = 0; i < 16; i++) rd_chk(1, 2'd3, 32'h0000_1000 + 3*i, "R10 data intact");
        rd_chk(1, 2'd1, 32'h8101, "R10 no extra word");
        wr(0, 2'd1, 32'h0000_C000);
    endtask

    task automatic t_simul;
        logic [31:0] v;
        wr(0, 2'd2, 32'h5555_0001);
        @(negedge clk);
        a_req = 1; a_we = 1; a_sel = 2'd2; a_wdata = 32'h5555_0002;
        b_req = 1; b_we = 0; b_sel = 2'd3;
        @(negedge clk);
        v = b_rdata;
        a_req = 0; b_req = 0;
        chk("R11 pop during push", v, 32'h5555_0001);
        rd_chk(1, 2'd1, 32'h8001, "R11 one word left");
        rd_chk(1, 2'd3, 32'h5555_0002, "R11 pushed word kept");
        rd_chk(0, 2'd1, 32'h8101, "R11 drained");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_sync();
        t_ctrl();
        t_disabled_push();
        t_order();
        t_peek();
        t_underflow();
        t_full();
        t_simul();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule